// File: doc/BRIEF.md
# Two-Byte I2C Port Expander Target

This block is an I2C target that gives a controller access to sixteen general-purpose pins, arranged as two byte-wide ports (port 0 and port 1). It oversamples SCL and SDA with the system clock and passes both lines through a spike filter. It then detects START and STOP, matches its 7-bit address, acknowledges, and moves data bytes. The address is a fixed five-bit prefix followed by two bits taken from the `addr_sel` pins.

There is no command byte and no register address. A single pointer picks the port for every data byte. The pointer starts at port 0 after each START or repeated START and flips after every byte until STOP. Write bytes land in output latches. Read bytes are snapshots of the pins, taken when each byte begins.

The pins are modelled as quasi-bidirectional. A latch bit of 1 lets the external level through. A latch bit of 0 holds the pin low, so it reads back as 0.

Top module: `pexp16_i2c_target`

## Requirements
- R1: After reset, `pin_out` is all ones, `sda_oe` is 0, and the block waits in idle for a START.
- R2: The block acknowledges only the address byte whose upper seven bits equal {ADDR_HI, addr_sel}. Bit 0 of that byte selects the direction: 1 means read. A transfer with any other address gets no ACK, and its data bytes leave `pin_out` unchanged.
- R3: In a write, the first data byte after the address sets `pin_out[7:0]` (port 0). The second data byte sets `pin_out[15:8]` (port 1).
- R4: Further write bytes before a STOP keep alternating, port 0 first, then port 1.
- R5: The target drives ACK (`sda_oe`=1) during the ninth clock of each write byte. The byte reaches its latch only when that ninth SCL pulse falls, and never earlier.
- R6: In a read, the first byte returns port 0, the second returns port 1, and later bytes keep alternating. Each byte is captured from the pins when that byte begins, so later pin changes do not affect it.
- R7: A read byte equals the port latch ANDed bitwise with that port's `pin_in` byte.
- R8: A START or repeated START returns the pointer to port 0. A STOP returns the block to idle with SDA released.
- R9: `sda_oe` is 1 only while the target sends an ACK or a 0 data bit. Read data goes out MSB first.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks has no effect.
- R11: If the controller returns NACK after a read byte, the target ends the transfer and keeps SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low reset, power-on or external |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases the line |
| addr_sel | input | 2 | Low two bits of the target address |
| pin_in | input | 16 | External levels of the sixteen pins |
| pin_out | output | 16 | Output latches, port 1 in bits 15:8 |

## Verification
The bench builds the block with FILT_LEN=3 and ADDR_HI=5'b10110, and runs the bus at about 1 MHz against a 50 MHz clock. With a three-clock filter, a two-clock spike falls just short of passing. This lets the bench show that an extra SCL pulse injected inside a data byte is dropped. The fixed prefix and an `addr_sel` value that changes during the run exercise both the address match and the address mismatch.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int PORT_W = 8;
  localparam int NPORT  = 2;
  localparam int WORD_W = NPORT * PORT_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } tgt_state_t;

  // 7-bit target address: fixed prefix, strap bits low
  function automatic logic [6:0] tgt_addr(input logic [4:0] hi, input logic [1:0] sel);
    return {hi, sel};
  endfunction

  // quasi-bidirectional readback: a latched 0 forces the pin low
  function automatic logic [PORT_W-1:0] qb_read(input logic [PORT_W-1:0] lat,
                                                input logic [PORT_W-1:0] pin);
    return lat & pin;
  endfunction

  function automatic logic [PORT_W-1:0] port_byte(input logic [WORD_W-1:0] v, input logic sel);
    return sel ? v[2*PORT_W-1:PORT_W] : v[PORT_W-1:0];
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic          clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      cnt     <= '0;
      clean_q <= 1'b1;
    end else begin
      sync <= {sync[0], raw};
      if (sync[1] != clean_q) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          clean_q <= sync[1];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign clean = clean_q;

  generate
    if (FILT_LEN >= 2) begin : g_chk
      // R10
      spike_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_q) |-> ($past(sync[1]) == $past(sync[1], 2)));
    end
  endgenerate
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import pexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic [6:0]        my_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic              sda_oe,
  output logic              wr_commit,
  output logic              wr_port,
  output logic [PORT_W-1:0] wr_byte
);
  logic scl_q, sda_q;
  tgt_state_t st;
  logic [3:0] bitc;
  logic [PORT_W-1:0] shr;
  logic ptr, rnw, m_ack;

  wire scl_rise  = scl & ~scl_q;
  wire scl_fall  = ~scl & scl_q;
  wire evt_start = scl & scl_q & sda_q & ~sda;
  wire evt_stop  = scl & scl_q & ~sda_q & sda;
  wire byte_done = (bitc == 4'd8);
  wire addr_hit  = (shr[7:1] == my_addr);
  wire [PORT_W-1:0] snap_now  = port_byte(rd_word, ptr);
  wire [PORT_W-1:0] snap_next = port_byte(rd_word, ~ptr);

  assign wr_commit = (st == ST_WACK) && scl_fall;
  assign wr_port   = ptr;
  assign wr_byte   = shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; st <= ST_IDLE; bitc <= '0; shr <= '0;
      ptr <= 1'b0; rnw <= 1'b0; m_ack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (evt_start) begin
        st <= ST_ADDR; bitc <= '0; ptr <= 1'b0; sda_oe <= 1'b0;
      end else if (evt_stop) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: ;
          ST_ADDR, ST_WDAT: begin
            if (scl_rise && !byte_done) begin
              shr  <= {shr[PORT_W-2:0], sda};
              bitc <= bitc + 1'b1;
            end else if (scl_fall && byte_done) begin
              bitc <= '0;
              if (st == ST_WDAT) begin
                st <= ST_WACK; sda_oe <= 1'b1;
              end else if (addr_hit) begin
                st <= ST_AACK; sda_oe <= 1'b1; rnw <= shr[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (rnw) begin
              st <= ST_RDAT; shr <= snap_now; sda_oe <= ~snap_now[PORT_W-1];
            end else begin
              st <= ST_WDAT; sda_oe <= 1'b0;
            end
          end
          ST_WACK: if (scl_fall) begin
            st <= ST_WDAT; sda_oe <= 1'b0; ptr <= ~ptr;
          end
          ST_RDAT: if (scl_fall) begin
            if (bitc == 4'd7) begin
              st <= ST_RACK; sda_oe <= 1'b0; bitc <= '0;
            end else begin
              shr    <= {shr[PORT_W-2:0], 1'b0};
              sda_oe <= ~shr[PORT_W-2];
              bitc   <= bitc + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) m_ack <= ~sda;
            if (scl_fall) begin
              ptr <= ~ptr;
              if (m_ack) begin
                st <= ST_RDAT; shr <= snap_next; sda_oe <= ~snap_next[PORT_W-1];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R9
  sda_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st inside {ST_AACK, ST_WACK, ST_RDAT}));
  // R8
  start_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> (ptr == 1'b0 && st == ST_ADDR));
  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> (st == ST_IDLE && !sda_oe));
  // R5
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (st == ST_WDAT && !sda_oe));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> ($past(scl_fall) || $past(evt_start)));
  // R11
  nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && scl_fall && !m_ack && !evt_stop && !evt_start) |=> (st == ST_IDLE && !sda_oe));
endmodule

// File: rtl/pexp16_i2c_target.sv
module pexp16_i2c_target
  import pexp_pkg::*;
#(
  parameter int         FILT_LEN = 4,
  parameter logic [4:0] ADDR_HI  = 5'b10110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic [WORD_W-1:0] pin_in,
  output logic [WORD_W-1:0] pin_out
);
  wire [1:0] raw = {scl_i, sda_i};
  wire [1:0] flt;
  logic [WORD_W-1:0] rd_word;
  logic wr_commit, wr_port;
  logic [PORT_W-1:0] wr_byte;
  logic [PORT_W-1:0] lat [NPORT];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_flt
      line_filter #(.FILT_LEN(FILT_LEN)) u_f (
        .clk(clk), .rst_n(rst_n), .raw(raw[g]), .clean(flt[g]));
    end
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat[p] <= '1;
        else if (wr_commit && wr_port == 1'(p)) lat[p] <= wr_byte;
      end
      assign pin_out[p*PORT_W +: PORT_W] = lat[p];
      assign rd_word[p*PORT_W +: PORT_W] = qb_read(lat[p], pin_in[p*PORT_W +: PORT_W]);
    end
  endgenerate

  xfer_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl(flt[1]), .sda(flt[0]),
    .my_addr(tgt_addr(ADDR_HI, addr_sel)), .rd_word(rd_word),
    .sda_oe(sda_oe), .wr_commit(wr_commit), .wr_port(wr_port), .wr_byte(wr_byte));

  // R5
  latch_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_out) |-> $past(wr_commit));
endmodule

// File: tb/sim_pexp16_i2c_target.sv
module sim_pexp16_i2c_target;
  localparam int Q = 12;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic [1:0] sel = 2'b01;
  logic [15:0] pin_in = 16'hFFFF;
  wire [15:0] pin_out;
  wire sda_oe;
  wire sda_bus = m_sda & ~sda_oe;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pexp16_i2c_target #(.FILT_LEN(3), .ADDR_HI(5'b10110)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(sel), .pin_in(pin_in), .pin_out(pin_out));

  // {wr port0, wr port1, pins, expected read port0, expected read port1}
  localparam logic [47:0] VEC [4] = '{
    {8'hFF, 8'hFF, 16'hA55A, 8'h5A, 8'hA5},
    {8'h0F, 8'hF0, 16'hFFFF, 8'h0F, 8'hF0},
    {8'h00, 8'hFF, 16'h1234, 8'h00, 8'h12},
    {8'hC3, 8'h3C, 16'h0F0F, 8'h03, 8'h0C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic wbit(input logic b, input logic spike = 1'b0);
    m_sda = b; wq();
    if (spike) begin
      scl = 1'b1; repeat (2) @(negedge clk); scl = 1'b0; wq();
    end
    scl = 1'b1; wq(2); scl = 1'b0; wq();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack, input int spike_bit = -1);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i], i == spike_bit);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rdata8(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
  endtask

  task automatic write2(input logic [7:0] a, input logic [7:0] b0, input logic [7:0] b1,
                        output logic acks);
    logic k0, k1, k2;
    i2c_start(); wbyte(a, k0); wbyte(b0, k1); wbyte(b1, k2); i2c_stop();
    acks = k0 & k1 & k2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pin_out reset", 32'(pin_out), 32'hFFFF);
    chk("R1 sda released", 32'(sda_oe), 32'h0);

    // table: write both ports, then read both back through the pins (R3, R6, R7)
    foreach (VEC[i]) begin
      write2(8'hB2, VEC[i][47:40], VEC[i][39:32], ack);
      chk("R2/R5 acks on write", 32'(ack), 32'h1);
      chk("R3 port latches", 32'(pin_out), 32'({VEC[i][39:32], VEC[i][47:40]}));
      pin_in = VEC[i][31:16];
      i2c_start(); wbyte(8'hB3, ack);
      rdata8(r); wbit(1'b0);
      chk("R7 read port0", 32'(r), 32'(VEC[i][15:8]));
      rdata8(r); wbit(1'b1);
      chk("R6 read port1", 32'(r), 32'(VEC[i][7:0]));
      i2c_stop();
    end

    // R2: foreign address ignored
    write2(8'hB6, 8'h00, 8'h00, ack);
    chk("R2 no ack foreign addr", 32'(ack), 32'h0);
    chk("R2 latches untouched", 32'(pin_out), 32'h3CC3);

    // R2: strap pins move the address
    sel = 2'b10;
    write2(8'hB4, 8'h7E, 8'h81, ack);
    chk("R2 strap address ack", 32'(ack), 32'h1);
    chk("R2 strap address data", 32'(pin_out), 32'h817E);
    sel = 2'b01;

    // R4: wrap after two bytes
    i2c_start(); wbyte(8'hB2, ack);
    wbyte(8'h11, ack); wbyte(8'h22, ack); wbyte(8'h33, ack); wbyte(8'h44, ack);
    i2c_stop();
    chk("R4 wrap to port0", 32'(pin_out), 32'h4433);

    // R8: repeated START resets pointer
    i2c_start(); wbyte(8'hB2, ack); wbyte(8'hAA, ack);
    i2c_start(); wbyte(8'hB2, ack); wbyte(8'hBB, ack);
    i2c_stop();
    chk("R8 rstart to port0", 32'(pin_out), 32'h44BB);

    // R5/R9: commit at end of ninth clock, SDA free during data
    i2c_start(); wbyte(8'hB2, ack);
    for (int i = 7; i >= 0; i--) begin
      wbit(1'b0);
      if (i == 4) chk("R9 sda free in write data", 32'(sda_oe), 32'h0);
    end
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    chk("R5 ack driven", 32'(sda_bus), 32'h0);
    chk("R5 no commit before fall", 32'(pin_out), 32'h44BB);
    wq(); scl = 1'b0; wq();
    chk("R5 commit after fall", 32'(pin_out), 32'h4400);
    i2c_stop();

    // R10: short SCL spike inside a byte is dropped
    i2c_start(); wbyte(8'hB2, ack);
    wbyte(8'h5A, ack, 3); wbyte(8'h66, ack);
    i2c_stop();
    chk("R10 spike rejected", 32'(pin_out), 32'h665A);

    // R6/R11: snapshot at byte start, three-byte read ended by NACK
    write2(8'hB2, 8'hFF, 8'hFF, ack);
    pin_in = 16'h1111;
    i2c_start(); wbyte(8'hB3, ack);
    pin_in = 16'h2222;
    rdata8(r);
    chk("R6 snapshot held", 32'(r), 32'h11);
    pin_in = 16'h3333; wbit(1'b0);
    rdata8(r);
    chk("R6 second byte port1", 32'(r), 32'h33);
    pin_in = 16'h4444; wbit(1'b0);
    rdata8(r);
    chk("R6 third byte port0", 32'(r), 32'h44);
    wbit(1'b1);
    repeat (4) @(negedge clk);
    chk("R11 released after nack", 32'(sda_oe), 32'h0);
    i2c_stop();
    chk("R8 idle after stop", 32'(sda_oe), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule